// File: doc/BRIEF.md
# Scratch RAM, Parallel Port and Interval Timer Peripheral

This peripheral sits on an 8-bit processor bus and packs three services into one selectable slave. The first is a 128-byte scratch memory. The second is a pair of 8-bit general-purpose ports whose pins are each set to input or output by their own direction bit. The third is an 8-bit down-counting interval timer. Software writes a start value to the timer, and the address of that write picks how many clocks pass between decrements. When the count passes below zero, the timer pulls an active-low interrupt line.

Two chip-select inputs must both be asserted for an access to happen. A separate active-low memory-select input then chooses between the scratch memory and the register file. Accesses take effect on the rising edge of `clk`. Read data is combinational while the block is selected and is zero otherwise. Each port pin is presented as three separate signals: an input level, an output level and an output enable.

Top module: `ram_io_timer`

## Requirements
- R1: An access happens only while `chipSel` is 1 and `chipSelN` is 0. Without that, no write changes any state and `dataOut` is 0.
- R2: With `ramSelN` at 0, the access goes to a 128-byte memory indexed by `addr[6:0]`. A write stores `dataIn` at the edge, and a read returns the stored byte combinationally.
- R3: With `ramSelN` at 1 and `addr[2]` at 0, `addr[1:0]` picks a register: 0 is the port A data latch, 1 is port A direction, 2 is the port B data latch and 3 is port B direction. Memory writes leave these registers unchanged.
- R4: A direction bit of 1 makes that pin an output. `portXOe` equals the direction register and `portXOut` equals the data latch. A data read returns the latch bit for output pins and the live `portXIn` bit for input pins.
- R5: A read with `ramSelN` at 1 and `addr[2]` at 1 returns the current timer count.
- R6: A write with `ramSelN` at 1, `addr[4]` at 1 and `addr[2]` at 1 loads the count with `dataIn`. `addr[1:0]` of 0, 1, 2 or 3 sets the decrement interval to 1, 8, 64 or 1024 clocks. A load of N underflows on the (N+1)·interval-th edge after the load edge.
- R7: On underflow the count becomes 0xFF, the interrupt flag is set and `irqN` goes to 0. From then until the next load, the count decrements on every clock, whatever the interval.
- R8: A load clears the interrupt flag and restarts the interval from the load edge. A timer read clears the flag at its edge. If an underflow happens on that same edge, the underflow wins.
- R9: Reset clears both direction and both data registers and the interrupt flag. It sets the count to 0xFF and the interval to 1024.
- R10: A write with `ramSelN` at 1, `addr[2]` at 1 and `addr[4]` at 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; accesses take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| chipSel | input | 1 | Active-high chip select |
| chipSelN | input | 1 | Active-low chip select |
| ramSelN | input | 1 | 0 selects scratch memory, 1 selects registers |
| rwN | input | 1 | 1 read, 0 write |
| addr | input | 7 | Address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, zero when not selected |
| portAIn | input | 8 | Port A pin levels |
| portAOut | output | 8 | Port A output levels |
| portAOe | output | 8 | Port A output enables |
| portBIn | input | 8 | Port B pin levels |
| portBOut | output | 8 | Port B output levels |
| portBOe | output | 8 | Port B output enables |
| irqN | output | 1 | Active-low timer interrupt |

## Verification
The port function is driven with mixed direction masks: half-output on port A and the opposite half on port B. The input pins are set to values that differ from the latches, so any bit that wrongly takes the latch or the pin shows up. Memory is tested at the lowest, highest and middle addresses, followed by register reads, which separates a decode overlap from a missing write. The timer is tested at every interval with small start values. The check edges fall right before and right after the expected underflow, so an off-by-one in the prescaler or the count is visible. A timer read placed on the underflow edge separates the set-over-clear priority from the reverse.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int PRESC_W = 10;

  typedef struct packed {
    logic       ramWe;
    logic       ramRe;
    logic       portWe;
    logic       portRe;
    logic [1:0] portIdx;
    logic       timerLoad;
    logic       timerRe;
    logic [1:0] scaleSel;
  } ctrlStrobe_t;

  // number of prescaler bits used per interval code: 1, 8, 64, 1024 clocks
  function automatic logic [3:0] scaleShift(input logic [1:0] code);
    case (code)
      2'd0:    scaleShift = 4'd0;
      2'd1:    scaleShift = 4'd3;
      2'd2:    scaleShift = 4'd6;
      default: scaleShift = 4'd10;
    endcase
  endfunction
endpackage

// File: rtl/rit_ctrl.sv
module rit_ctrl
  import rit_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          chipSel,
  input  logic          chipSelN,
  input  logic          ramSelN,
  input  logic          rwN,
  input  logic [AW-1:0] addr,
  output logic          selected,
  output ctrlStrobe_t   stb
);
  logic ramHit, regHit, isWrite;

  always_comb begin
    selected = chipSel & ~chipSelN;
    ramHit   = selected & ~ramSelN;
    regHit   = selected & ramSelN;
    isWrite  = ~rwN;

    stb.ramWe     = ramHit & isWrite;
    stb.ramRe     = ramHit & rwN;
    stb.portWe    = regHit & isWrite & ~addr[2];
    stb.portRe    = regHit & rwN & ~addr[2];
    stb.portIdx   = addr[1:0];
    stb.timerLoad = regHit & isWrite & addr[2] & addr[4];
    stb.timerRe   = regHit & rwN & addr[2];
    stb.scaleSel  = addr[1:0];
  end
endmodule

// File: rtl/rit_datapath.sv
module rit_datapath
  import rit_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int PW = PRESC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrobe_t   stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  input  logic [DW-1:0] portAIn,
  output logic [DW-1:0] portAOut,
  output logic [DW-1:0] portAOe,
  input  logic [DW-1:0] portBIn,
  output logic [DW-1:0] portBOut,
  output logic [DW-1:0] portBOe,
  output logic          irqN
);
  localparam int RAM_DEPTH = 1 << AW;

  // ---------------- scratch memory (no reset) ----------------
  logic [DW-1:0] mem [RAM_DEPTH];
  always_ff @(posedge clk) begin
    if (stb.ramWe) mem[addr] <= dataIn;
  end

  // ---------------- ports ----------------
  logic [DW-1:0] latchA, dirA, latchB, dirB;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchA <= '0; dirA <= '0; latchB <= '0; dirB <= '0;
    end else if (stb.portWe) begin
      case (stb.portIdx)
        2'd0: latchA <= dataIn;
        2'd1: dirA   <= dataIn;
        2'd2: latchB <= dataIn;
        default: dirB <= dataIn;
      endcase
    end
  end
  assign portAOut = latchA;
  assign portAOe  = dirA;
  assign portBOut = latchB;
  assign portBOe  = dirB;

  logic [DW-1:0] pinViewA, pinViewB, portRead;
  always_comb begin
    pinViewA = (latchA & dirA) | (portAIn & ~dirA);
    pinViewB = (latchB & dirB) | (portBIn & ~dirB);
    case (stb.portIdx)
      2'd0: portRead = pinViewA;
      2'd1: portRead = dirA;
      2'd2: portRead = pinViewB;
      default: portRead = dirB;
    endcase
  end

  // ---------------- interval timer ----------------
  logic [DW-1:0] timerCount;
  logic [PW-1:0] prescCnt, prescMask;
  logic [1:0]    scaleCode;
  logic          expired, irqFlag, tick, underflow;

  always_comb begin
    prescMask = PW'((1 << scaleShift(scaleCode)) - 1);
    tick      = expired | (prescCnt == prescMask);
    underflow = ~expired & tick & (timerCount == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timerCount <= '1;
      scaleCode  <= 2'd3;
      prescCnt   <= '0;
      expired    <= 1'b0;
      irqFlag    <= 1'b0;
    end else if (stb.timerLoad) begin
      timerCount <= dataIn;
      scaleCode  <= stb.scaleSel;
      prescCnt   <= '0;
      expired    <= 1'b0;
      irqFlag    <= 1'b0;
    end else begin
      prescCnt <= tick ? '0 : prescCnt + 1'b1;
      if (tick) timerCount <= timerCount - 1'b1;
      if (underflow) begin
        expired <= 1'b1;
        irqFlag <= 1'b1;
      end else if (stb.timerRe) begin
        irqFlag <= 1'b0;
      end
    end
  end
  assign irqN = ~irqFlag;

  // ---------------- read mux ----------------
  always_comb begin
    dataOut = '0;
    if (stb.ramRe)       dataOut = mem[addr];
    else if (stb.portRe) dataOut = portRead;
    else if (stb.timerRe) dataOut = timerCount;
  end

  // ---------------- assertions ----------------
  a_r4_dir_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.portWe && stb.portIdx == 2'd1) |=> portAOe == $past(dataIn));

  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stb.timerLoad |=> (irqN && timerCount == $past(dataIn)));

  a_r7_wrap_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqN) |-> timerCount == '1);

  a_r7_fast_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !stb.timerLoad) |=> timerCount == $past(timerCount) - 1'b1);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.timerRe && !stb.timerLoad && !underflow) |=> irqN);
endmodule

// File: rtl/ram_io_timer.sv
module ram_io_timer
  import rit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chipSel,
  input  logic              chipSelN,
  input  logic              ramSelN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  input  logic [DATA_W-1:0] portAIn,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAOe,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] portBOut,
  output logic [DATA_W-1:0] portBOe,
  output logic              irqN
);
  ctrlStrobe_t stb;
  logic        selected;

  rit_ctrl #(.AW(ADDR_W)) u_ctrl (
    .chipSel(chipSel), .chipSelN(chipSelN), .ramSelN(ramSelN), .rwN(rwN),
    .addr(addr), .selected(selected), .stb(stb)
  );

  rit_datapath #(.DW(DATA_W), .AW(ADDR_W), .PW(PRESC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe), .irqN(irqN)
  );

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> dataOut == '0);

  a_r1_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |=> ($stable(portAOut) && $stable(portAOe) && $stable(portBOut) && $stable(portBOe)));
endmodule

// File: tb/ram_io_timer_bench.sv
`timescale 1ns/1ps
module ram_io_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chipSel = 1'b0, chipSelN = 1'b1, ramSelN = 1'b1, rwN = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] dataIn = '0, portAIn = '0, portBIn = '0;
  logic [7:0] dataOut, portAOut, portAOe, portBOut, portBOe;
  logic irqN;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ram_io_timer u_ram_io_timer (
    .clk(clk), .rst_n(rst_n), .chipSel(chipSel), .chipSelN(chipSelN),
    .ramSelN(ramSelN), .rwN(rwN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe), .irqN(irqN)
  );

  // {isRead, isRam, addr[6:0], wdata, pinA, pinB, expect}
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 1'b0, 7'h01, 8'hF0, 8'h00, 8'h00, 8'h00},
    {1'b0, 1'b0, 7'h00, 8'hA5, 8'h00, 8'h00, 8'h00},
    {1'b1, 1'b0, 7'h00, 8'h00, 8'h3C, 8'h00, 8'hAC},
    {1'b1, 1'b0, 7'h01, 8'h00, 8'h3C, 8'h00, 8'hF0},
    {1'b0, 1'b0, 7'h03, 8'h0F, 8'h3C, 8'h00, 8'h00},
    {1'b0, 1'b0, 7'h02, 8'h96, 8'h3C, 8'h00, 8'h00},
    {1'b1, 1'b0, 7'h02, 8'h00, 8'h3C, 8'hC3, 8'hC6},
    {1'b0, 1'b1, 7'h00, 8'h11, 8'h3C, 8'hC3, 8'h00},
    {1'b0, 1'b1, 7'h7F, 8'hEE, 8'h3C, 8'hC3, 8'h00},
    {1'b0, 1'b1, 7'h40, 8'h5A, 8'h3C, 8'hC3, 8'h00},
    {1'b1, 1'b1, 7'h00, 8'h00, 8'h3C, 8'hC3, 8'h11},
    {1'b1, 1'b1, 7'h7F, 8'h00, 8'h3C, 8'hC3, 8'hEE},
    {1'b1, 1'b1, 7'h40, 8'h00, 8'h3C, 8'hC3, 8'h5A},
    {1'b1, 1'b0, 7'h03, 8'h00, 8'h3C, 8'hC3, 8'h0F},
    {1'b0, 1'b0, 7'h01, 8'h00, 8'h3C, 8'hC3, 8'h00},
    {1'b1, 1'b0, 7'h00, 8'h00, 8'h3C, 8'hC3, 8'h3C}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic isRam, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    chipSel = 1'b1; chipSelN = 1'b0; ramSelN = ~isRam; rwN = 1'b0; addr = a; dataIn = d;
    @(posedge clk); #1;
    chipSel = 1'b0; chipSelN = 1'b1; rwN = 1'b1;
  endtask

  task automatic busRead(input logic isRam, input logic [6:0] a, output logic [7:0] q);
    @(negedge clk);
    chipSel = 1'b1; chipSelN = 1'b0; ramSelN = ~isRam; rwN = 1'b1; addr = a;
    #1 q = dataOut;
    @(posedge clk); #1;
    chipSel = 1'b0; chipSelN = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [7:0] expSeq [7];
    expSeq = '{8'h03, 8'h02, 8'h01, 8'h00, 8'hFF, 8'hFE, 8'hFD};

    // R9: reset state
    portAIn = 8'h5C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R9 portAOe", portAOe, 8'h00);
    check("R9 portAOut", portAOut, 8'h00);
    check("R9 irqN", {7'b0, irqN}, 8'h01);
    busRead(1'b0, 7'h00, q); check("R9/R4 inputs after reset", q, 8'h5C);
    busRead(1'b0, 7'h04, q); check("R9/R5 count after reset", q, 8'hFF);

    // vector table: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      portAIn = v[23:16]; portBIn = v[15:8];
      if (v[40]) begin
        busRead(v[39], v[38:32], q);
        check($sformatf("R2/R3/R4 vector %0d", i), q, v[7:0]);
      end else begin
        busWrite(v[39], v[38:32], v[31:24]);
      end
    end
    check("R4 portAOut latch", portAOut, 8'hA5);
    check("R4 portBOe dir", portBOe, 8'h0F);
    check("R4 portBOut latch", portBOut, 8'h96);

    // R1: deselected writes ignored, dataOut zero
    busWrite(1'b0, 7'h01, 8'hFF);
    @(negedge clk);
    chipSel = 1'b0; chipSelN = 1'b0; ramSelN = 1'b1; rwN = 1'b0; addr = 7'h00; dataIn = 8'h00;
    #1 check("R1 dataOut idle cs low", dataOut, 8'h00);
    @(posedge clk); #1;
    chipSel = 1'b1; chipSelN = 1'b1;
    @(posedge clk); #1;
    chipSel = 1'b0; rwN = 1'b1;
    check("R1 latch kept", portAOut, 8'hA5);
    check("R1 dir kept", portAOe, 8'hFF);

    // R6 R7 R8: interval 1, read on underflow edge
    busWrite(1'b0, 7'h14, 8'h03);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chipSel = 1'b1; chipSelN = 1'b0; ramSelN = 1'b1; rwN = 1'b1; addr = 7'h04;
      #1;
      check($sformatf("R6/R7 count step %0d", k), dataOut, expSeq[k]);
      check($sformatf("R7/R8 irqN step %0d", k), {7'b0, irqN}, (k == 4) ? 8'h00 : 8'h01);
      @(posedge clk); #1;
      chipSel = 1'b0; chipSelN = 1'b1;
    end

    // R6: interval 8, N=2 -> flag after 24 edges
    busWrite(1'b0, 7'h15, 8'h02);
    idle(23); check("R6 x8 before", {7'b0, irqN}, 8'h01);
    idle(1);  check("R6/R7 x8 at underflow", {7'b0, irqN}, 8'h00);
    busRead(1'b0, 7'h04, q); check("R7 wrap value", q, 8'hFF);
    check("R8 read clears", {7'b0, irqN}, 8'h01);

    // R6: interval 64, N=1 -> 128 edges; R8 load clears
    busWrite(1'b0, 7'h16, 8'h01);
    idle(127); check("R6 x64 before", {7'b0, irqN}, 8'h01);
    idle(1);   check("R6 x64 at underflow", {7'b0, irqN}, 8'h00);
    busWrite(1'b0, 7'h14, 8'h50);
    check("R8 load clears flag", {7'b0, irqN}, 8'h01);
    busRead(1'b0, 7'h04, q); check("R8 load value", q, 8'h50);

    // R6: interval 1024, N=0
    busWrite(1'b0, 7'h17, 8'h00);
    idle(1023); check("R6 x1024 before", {7'b0, irqN}, 8'h01);
    idle(1);    check("R6 x1024 at underflow", {7'b0, irqN}, 8'h00);

    // R8: prescaler restart on reload
    busWrite(1'b0, 7'h15, 8'h05);
    idle(5);
    busWrite(1'b0, 7'h15, 8'h05);
    idle(7);
    busRead(1'b0, 7'h04, q); check("R8 restart hold", q, 8'h05);
    busRead(1'b0, 7'h04, q); check("R8 restart step", q, 8'h04);

    // R10: write to A2=1, A4=0 ignored
    busWrite(1'b0, 7'h17, 8'h40);
    busWrite(1'b0, 7'h04, 8'h11);
    busRead(1'b0, 7'h04, q); check("R10 ignored write", q, 8'h40);
    busRead(1'b0, 7'h00, q); check("R10 port A untouched", q, 8'hA5);

    // R9: reset mid-run
    busWrite(1'b0, 7'h14, 8'h00);
    idle(2);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R9 dirA cleared", portAOe, 8'h00);
    check("R9 dirB cleared", portBOe, 8'h00);
    check("R9 latchA cleared", portAOut, 8'h00);
    check("R9 irq cleared", {7'b0, irqN}, 8'h01);
    idle(2);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule